// File: doc/BRIEF.md
# Byte-Serial Counter Host Interface

This block sits between a host processor's 8-bit bus and a two-axis, 24-bit up/down counter core. The host sees a single data port per axis and a single control port. Data writes fill the 24-bit preset register one byte at a time. Data reads drain the 24-bit output latch one byte at a time. Both go through a byte pointer that advances by itself after each data access. Control writes land in per-axis mode, I/O and index configuration registers, or in a reset/load decoder. The decoder turns command bits into single-cycle strobes for the counter core. Control reads return the addressed axis's flag byte, which the core supplies.

The bus strobes are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and its rising (trailing) edge is detected. The address and data fields are captured while the synchronized strobe is low. The bus master must therefore hold chip select, control/data, axis select and the write data for two clock periods after releasing the strobe. Read data is driven combinationally from the current pointer, so the byte appears as soon as the read strobe and chip select are both low.

Top module: `cntr_host_if`

## Requirements
- R1: After a synchronous active-low reset, all presets, output latches, byte pointers and configuration registers are zero, no command strobe is high, and the bus output enable is low.
- R2: `bus_doe` is high exactly while `bus_cs_n` and `bus_rd_n` are both low.
- R3: A data write (`bus_cd`=0) stores `bus_din` into the preset byte of the axis given by `bus_axis` (0 = X, 1 = Y). The byte is the one that axis's pointer addresses: pointer 0 is bits 7:0, 1 is bits 15:8, 2 is bits 23:16. The pointer then steps 0→1→2→0.
- R4: A data read returns output-latch byte `ptr` of the selected axis, using the same byte positions as R3. The pointer steps at the trailing edge of the read, so four reads after a pointer reset return the low, middle, high, then low byte again.
- R5: A control read (`bus_cd`=1) returns the 8-bit core flag byte of the selected axis: `core_flags_i[7:0]` for X and `core_flags_i[15:8]` for Y.
- R6: A strobe while `bus_cs_n` is high has no effect on any register, pointer or strobe.
- R7: In a control write, `bus_din[6:5]` selects the target: 01 mode, 10 I/O control, 11 index control. Bits 4:0 are stored in that 5-bit register of the selected axis. The other axis is left unchanged.
- R8: In a control write, `bus_din[7]`=1 applies the write to both axes, whatever the value of `bus_axis`.
- R9: A reset/load command (`bus_din[6:5]`=00) with bit 0 set returns the axis's byte pointer to 0.
- R10: Reset/load bits 2:1 raise one strobe on the addressed axis: 01 reset counter, 10 clear toggle/sign flags, 11 clear error. 00 raises none.
- R11: Reset/load bits 4:3 act on the addressed axis. 01 strobes a preset-to-counter load. 10 copies all 24 bits of `core_count_i` into the output latch in one cycle and strobes the latch output. 11 strobes a prescaler load. 00 does nothing.
- R12: Every command strobe is high for exactly one clock cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_cd | input | 1 | 1 = control register, 0 = data register |
| bus_axis | input | 1 | 0 = X axis, 1 = Y axis |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Read data to the host |
| bus_doe | output | 1 | Read data drive enable |
| core_count_i | input | 48 | Live counter values, X in bits 23:0 |
| core_flags_i | input | 16 | Core flag bytes, X in bits 7:0 |
| preset_o | output | 48 | Preset registers, X in bits 23:0 |
| mode_o | output | 10 | 5-bit mode configuration per axis |
| ioctl_o | output | 10 | 5-bit I/O configuration per axis |
| index_o | output | 10 | 5-bit index configuration per axis |
| stb_rst_cnt_o | output | 2 | Reset-counter strobe per axis |
| stb_clr_flags_o | output | 2 | Clear-toggle/sign-flags strobe per axis |
| stb_clr_err_o | output | 2 | Clear-error strobe per axis |
| stb_load_cnt_o | output | 2 | Preset-to-counter strobe per axis |
| stb_latch_o | output | 2 | Counter-to-latch strobe per axis |
| stb_load_psc_o | output | 2 | Prescaler-load strobe per axis |

## Verification
Pointer wrap-around is the hardest situation to reach. The pointer is invisible at the ports, so its position has to be inferred from where a later byte lands. The stimulus resets the pointer and then makes a fourth data write or read. It also places deselected strobes between real accesses, so a hidden pointer step would show up as a misplaced byte. The reset/load decoder is swept over all 32 low-field codes on both axes, and each strobe's pulse count is compared.

// File: rtl/cntr_host_pkg.sv
// Shared types for the counter host interface.
// Assumes exactly two axes, selected by one bus bit.
package cntr_host_pkg;
    localparam int AXES = 2;

    typedef enum logic [1:0] {
        TGT_RLD   = 2'd0,
        TGT_MODE  = 2'd1,
        TGT_IOCTL = 2'd2,
        TGT_INDEX = 2'd3
    } ctl_tgt_e;

    typedef struct packed {
        logic       cs_n;
        logic       cd;
        logic       axis;
        logic [7:0] data;
    } bus_fields_t;

    typedef struct packed {
        logic ptr_rst;
        logic rst_cnt;
        logic clr_flags;
        logic clr_err;
        logic load_cnt;
        logic latch;
        logic load_psc;
    } rld_cmd_t;
endpackage

// File: rtl/cntr_bus_sync.sv
// Synchronizes the bus strobes into clk and reports each trailing edge as a
// one-cycle event. It captures the bus fields while the synchronized strobe
// is low. Assumes the fields stay stable for SYNC_STAGES clocks after the
// strobe rises.
module cntr_bus_sync
    import cntr_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        cd,
    input  logic        axis,
    input  logic [7:0]  din,
    output logic        rd_evt,
    output logic        wr_evt,
    output bus_fields_t fields
);
    logic [SYNC_STAGES:0] rd_pipe;
    logic [SYNC_STAGES:0] wr_pipe;
    logic                 any_low;

    // Shift the strobe levels through the synchronizer and edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pipe <= '1;
            wr_pipe <= '1;
        end else begin
            rd_pipe <= {rd_pipe[SYNC_STAGES-1:0], rd_n};
            wr_pipe <= {wr_pipe[SYNC_STAGES-1:0], wr_n};
        end
    end

    assign rd_evt  = rd_pipe[SYNC_STAGES-1] & ~rd_pipe[SYNC_STAGES];
    assign wr_evt  = wr_pipe[SYNC_STAGES-1] & ~wr_pipe[SYNC_STAGES];
    assign any_low = ~rd_pipe[SYNC_STAGES-1] | ~wr_pipe[SYNC_STAGES-1];

    // Hold the bus fields seen during the active part of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields <= '{cs_n: 1'b1, cd: 1'b0, axis: 1'b0, data: 8'h00};
        end else if (any_low) begin
            fields <= '{cs_n: cs_n, cd: cd, axis: axis, data: din};
        end
    end

    AST_WR_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt); // R12
    AST_RD_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> !rd_evt); // R12
endmodule

// File: rtl/cntr_cmd_decode.sv
// Turns a qualified bus event and its captured fields into per-axis
// register enables and a reset/load command. Purely combinational.
module cntr_cmd_decode
    import cntr_host_pkg::*;
#(
    parameter int CFG_W = 5
) (
    input  logic             rd_evt,
    input  logic             wr_evt,
    input  bus_fields_t      fields,
    output logic [AXES-1:0]  axis_hit,
    output logic             data_wr,
    output logic             data_rd,
    output logic             mode_we,
    output logic             io_we,
    output logic             idx_we,
    output logic [CFG_W-1:0] cfg_data,
    output logic [7:0]       wr_byte,
    output rld_cmd_t         rld
);
    logic     ctl_wr;
    logic     rld_we;
    ctl_tgt_e tgt;

    // Qualify events by chip select and split data from control traffic.
    always_comb begin
        ctl_wr  = wr_evt & ~fields.cs_n & fields.cd;
        data_wr = wr_evt & ~fields.cs_n & ~fields.cd;
        data_rd = rd_evt & ~fields.cs_n & ~fields.cd;
        tgt     = ctl_tgt_e'(fields.data[6:5]);
        mode_we = ctl_wr && (tgt == TGT_MODE);
        io_we   = ctl_wr && (tgt == TGT_IOCTL);
        idx_we  = ctl_wr && (tgt == TGT_INDEX);
        rld_we  = ctl_wr && (tgt == TGT_RLD);
        cfg_data = fields.data[CFG_W-1:0];
        wr_byte  = fields.data;
    end

    // Pick the addressed axis; bit 7 of a control write broadcasts.
    always_comb begin
        if (fields.cd && fields.data[7]) axis_hit = '1;
        else if (fields.axis)            axis_hit = 2'b10;
        else                             axis_hit = 2'b01;
    end

    // Decode the reset/load command fields.
    always_comb begin
        rld.ptr_rst   = rld_we & fields.data[0];
        rld.rst_cnt   = rld_we & (fields.data[2:1] == 2'b01);
        rld.clr_flags = rld_we & (fields.data[2:1] == 2'b10);
        rld.clr_err   = rld_we & (fields.data[2:1] == 2'b11);
        rld.load_cnt  = rld_we & (fields.data[4:3] == 2'b01);
        rld.latch     = rld_we & (fields.data[4:3] == 2'b10);
        rld.load_psc  = rld_we & (fields.data[4:3] == 2'b11);
    end
endmodule

// File: rtl/cntr_axis_regs.sv
// Register set of one axis: preset, output latch, byte pointer, three
// configuration registers and the registered command strobes.
// Assumes that enables from the decoder are one-cycle pulses.
module cntr_axis_regs
    import cntr_host_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    parameter int CFG_W  = 5,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int PTR_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              mode_we,
    input  logic              io_we,
    input  logic              idx_we,
    input  logic [CFG_W-1:0]  cfg_data,
    input  rld_cmd_t          rld,
    input  logic [CNT_W-1:0]  core_count,
    output logic [CNT_W-1:0]  preset,
    output logic [CNT_W-1:0]  latch,
    output logic [PTR_W-1:0]  ptr,
    output logic [CFG_W-1:0]  mode,
    output logic [CFG_W-1:0]  ioctl,
    output logic [CFG_W-1:0]  index,
    output logic [5:0]        stb
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

    logic access;
    assign access = hit & (data_wr | data_rd);

    // Byte pointer: reset by command, else step with wrap on data access.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ptr <= '0;
        else if (hit && rld.ptr_rst) ptr <= '0;
        else if (access)            ptr <= (ptr == LAST) ? '0 : ptr + PTR_W'(1);
    end

    // Preset: write the byte addressed by the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preset <= '0;
        end else if (hit && data_wr) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (ptr == PTR_W'(b)) preset[b*BYTE_W +: BYTE_W] <= wr_byte;
            end
        end
    end

    // Output latch: parallel capture of the live counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                latch <= '0;
        else if (hit && rld.latch) latch <= core_count;
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= '0;
            ioctl <= '0;
            index <= '0;
        end else if (hit) begin
            if (mode_we) mode  <= cfg_data;
            if (io_we)   ioctl <= cfg_data;
            if (idx_we)  index <= cfg_data;
        end
    end

    // Command strobes, one cycle per decoded command.
    always_ff @(posedge clk) begin
        if (!rst_n)   stb <= '0;
        else if (hit) stb <= {rld.load_psc, rld.latch, rld.load_cnt,
                              rld.clr_err, rld.clr_flags, rld.rst_cnt};
        else          stb <= '0;
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST); // R3
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        access && !rld.ptr_rst |=>
        ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + PTR_W'(1))); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(access || (hit && rld.ptr_rst)) |=> $stable(ptr)); // R6
    AST_PRESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && data_wr) |=> $stable(preset)); // R6
    AST_LATCH_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
        hit && rld.latch |=> latch == $past(core_count)); // R11
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        |stb |=> ~|stb); // R12
endmodule

// File: rtl/cntr_host_if.sv
// Top of the counter host interface: bus synchronizer, command decoder,
// one register set per axis and the combinational read-back mux.
// Assumes the bus fields are held SYNC_STAGES clocks past each strobe.
module cntr_host_if
    import cntr_host_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int BYTE_W      = 8,
    parameter int CFG_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_cs_n,
    input  logic                   bus_rd_n,
    input  logic                   bus_wr_n,
    input  logic                   bus_cd,
    input  logic                   bus_axis,
    input  logic [7:0]             bus_din,
    output logic [7:0]             bus_dout,
    output logic                   bus_doe,
    input  logic [AXES*CNT_W-1:0]  core_count_i,
    input  logic [AXES*8-1:0]      core_flags_i,
    output logic [AXES*CNT_W-1:0]  preset_o,
    output logic [AXES*CFG_W-1:0]  mode_o,
    output logic [AXES*CFG_W-1:0]  ioctl_o,
    output logic [AXES*CFG_W-1:0]  index_o,
    output logic [AXES-1:0]        stb_rst_cnt_o,
    output logic [AXES-1:0]        stb_clr_flags_o,
    output logic [AXES-1:0]        stb_clr_err_o,
    output logic [AXES-1:0]        stb_load_cnt_o,
    output logic [AXES-1:0]        stb_latch_o,
    output logic [AXES-1:0]        stb_load_psc_o
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int PTR_W  = $clog2(NBYTES);

    logic              rd_evt, wr_evt;
    bus_fields_t       fields;
    logic [AXES-1:0]   axis_hit;
    logic              data_wr, data_rd, mode_we, io_we, idx_we;
    logic [CFG_W-1:0]  cfg_data;
    logic [7:0]        wr_byte;
    rld_cmd_t          rld;
    logic [CNT_W-1:0]  latch_all [AXES];
    logic [PTR_W-1:0]  ptr_all   [AXES];
    logic [5:0]        stb_all   [AXES];
    logic [CNT_W-1:0]  lat_sel;
    logic [PTR_W-1:0]  ptr_sel;
    logic [7:0]        lat_byte;

    cntr_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .rd_n(bus_rd_n),
        .wr_n(bus_wr_n), .cd(bus_cd), .axis(bus_axis), .din(bus_din),
        .rd_evt(rd_evt), .wr_evt(wr_evt), .fields(fields)
    );

    cntr_cmd_decode #(.CFG_W(CFG_W)) u_dec (
        .rd_evt(rd_evt), .wr_evt(wr_evt), .fields(fields),
        .axis_hit(axis_hit), .data_wr(data_wr), .data_rd(data_rd),
        .mode_we(mode_we), .io_we(io_we), .idx_we(idx_we),
        .cfg_data(cfg_data), .wr_byte(wr_byte), .rld(rld)
    );

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        cntr_axis_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .CFG_W(CFG_W)) u_regs (
            .clk(clk), .rst_n(rst_n), .hit(axis_hit[g]),
            .data_wr(data_wr), .data_rd(data_rd),
            .wr_byte(wr_byte[BYTE_W-1:0]),
            .mode_we(mode_we), .io_we(io_we), .idx_we(idx_we),
            .cfg_data(cfg_data), .rld(rld),
            .core_count(core_count_i[g*CNT_W +: CNT_W]),
            .preset(preset_o[g*CNT_W +: CNT_W]),
            .latch(latch_all[g]), .ptr(ptr_all[g]),
            .mode(mode_o[g*CFG_W +: CFG_W]),
            .ioctl(ioctl_o[g*CFG_W +: CFG_W]),
            .index(index_o[g*CFG_W +: CFG_W]),
            .stb(stb_all[g])
        );
        assign stb_rst_cnt_o[g]   = stb_all[g][0];
        assign stb_clr_flags_o[g] = stb_all[g][1];
        assign stb_clr_err_o[g]   = stb_all[g][2];
        assign stb_load_cnt_o[g]  = stb_all[g][3];
        assign stb_latch_o[g]     = stb_all[g][4];
        assign stb_load_psc_o[g]  = stb_all[g][5];
    end

    // Select the latch byte addressed by the selected axis's pointer.
    always_comb begin
        lat_sel  = latch_all[bus_axis];
        ptr_sel  = ptr_all[bus_axis];
        lat_byte = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (ptr_sel == PTR_W'(b)) lat_byte = 8'(lat_sel[b*BYTE_W +: BYTE_W]);
        end
    end

    // Read-back mux: flag byte for control reads, latch byte for data reads.
    always_comb begin
        bus_doe  = ~bus_cs_n & ~bus_rd_n;
        bus_dout = bus_cd ? (bus_axis ? core_flags_i[15:8] : core_flags_i[7:0])
                          : lat_byte;
    end

    AST_DOE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> !bus_doe); // R2
    AST_STROBES_AXIS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stb_latch_o) > 0 |-> $past(rld.latch)); // R11
endmodule

// File: tb/tb_cntr_host_if.sv
module tb_cntr_host_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic        bus_cd = 1'b0, bus_axis = 1'b0;
    logic [7:0]  bus_din = 8'h00;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic [47:0] core_count_i = 48'h0;
    logic [15:0] core_flags_i = 16'h0;
    logic [47:0] preset_o;
    logic [9:0]  mode_o, ioctl_o, index_o;
    logic [1:0]  s_rst, s_clrf, s_clre, s_ldc, s_lat, s_psc;

    int checks = 0;
    int fails  = 0;
    int stb_cnt [12];
    int long_pulses = 0;
    logic [11:0] stb_vec, stb_prev;
    logic [7:0]  rbyte;
    logic        rdoe;
    logic [23:0] exp_pre [2];
    logic [4:0]  exp_cfg [3][2];

    always #10 clk = ~clk;

    cntr_host_if dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_cd(bus_cd), .bus_axis(bus_axis),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .core_count_i(core_count_i), .core_flags_i(core_flags_i),
        .preset_o(preset_o), .mode_o(mode_o), .ioctl_o(ioctl_o),
        .index_o(index_o), .stb_rst_cnt_o(s_rst), .stb_clr_flags_o(s_clrf),
        .stb_clr_err_o(s_clre), .stb_load_cnt_o(s_ldc),
        .stb_latch_o(s_lat), .stb_load_psc_o(s_psc)
    );

    // Index = kind*2 + axis; kinds: rst, clr flags, clr err, load cnt, latch, psc.
    assign stb_vec = {s_psc, s_lat, s_ldc, s_clre, s_clrf, s_rst};

    always @(posedge clk) begin
        if (!rst_n) stb_prev <= '0;
        else begin
            for (int i = 0; i < 12; i++) if (stb_vec[i]) stb_cnt[i] = stb_cnt[i] + 1;
            if (|(stb_vec & stb_prev)) long_pulses = long_pulses + 1;
            stb_prev <= stb_vec;
        end
    end

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic cs, input logic cd, input logic ax, input logic [7:0] d);
        @(negedge clk);
        bus_cs_n = cs; bus_cd = cd; bus_axis = ax; bus_din = d; bus_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (5) @(negedge clk);
        bus_cs_n = 1'b1;
    endtask

    task automatic bus_read(input logic cs, input logic cd, input logic ax,
                            output logic [7:0] d, output logic oe);
        @(negedge clk);
        bus_cs_n = cs; bus_cd = cd; bus_axis = ax; bus_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        d = bus_dout; oe = bus_doe;
        bus_rd_n = 1'b1;
        repeat (5) @(negedge clk);
        bus_cs_n = 1'b1;
    endtask

    function automatic bit fires(input int kind, input logic [4:0] c);
        case (kind)
            0: return c[2:1] == 2'b01;
            1: return c[2:1] == 2'b10;
            2: return c[2:1] == 2'b11;
            3: return c[4:3] == 2'b01;
            4: return c[4:3] == 2'b10;
            default: return c[4:3] == 2'b11;
        endcase
    endfunction

    function automatic logic [4:0] cfg_of(input int t, input int a);
        case (t)
            0: return mode_o[a*5 +: 5];
            1: return ioctl_o[a*5 +: 5];
            default: return index_o[a*5 +: 5];
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int snap [12];
        logic [23:0] cval;
        for (int i = 0; i < 12; i++) stb_cnt[i] = 0;
        for (int t = 0; t < 3; t++) for (int a = 0; a < 2; a++) exp_cfg[t][a] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 preset", preset_o, 48'h0);
        check("R1 cfg", {mode_o, ioctl_o, index_o}, 30'h0);
        check("R1 strobes", {36'h0, stb_vec}, 48'h0);
        check("R1 doe", bus_doe, 1'b0);
        bus_read(1'b0, 1'b0, 1'b0, rbyte, rdoe);
        check("R1 latch byte", rbyte, 8'h00);

        // R2 output enable truth table
        bus_cs_n = 1'b0; bus_rd_n = 1'b1; #1 check("R2 cs only", bus_doe, 1'b0);
        bus_cs_n = 1'b1; bus_rd_n = 1'b0; #1 check("R2 rd only", bus_doe, 1'b0);
        bus_cs_n = 1'b0; #1 check("R2 both", bus_doe, 1'b1);
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
        repeat (6) @(negedge clk);

        // R3/R9 preset byte order and wrap per axis
        for (int a = 0; a < 2; a++) begin
            exp_pre[a] = '0;
            bus_write(1'b0, 1'b1, a[0], 8'h01);          // pointer reset
            for (int k = 0; k < 4; k++) begin
                logic [7:0] v;
                v = 8'(8'h21 * (k + 1) + 8'h40 * a);
                exp_pre[a][(k % 3)*8 +: 8] = v;
                bus_write(1'b0, 1'b0, a[0], v);
                check("R3 preset", preset_o[a*24 +: 24], exp_pre[a]);
            end
        end
        check("R3 other axis", preset_o[23:0], exp_pre[0]);

        // R6 deselected write changes nothing; next real write hits middle byte
        bus_write(1'b1, 1'b0, 1'b0, 8'hEE);
        check("R6 no write", preset_o[23:0], exp_pre[0]);
        bus_write(1'b0, 1'b0, 1'b0, 8'h5A);
        exp_pre[0][15:8] = 8'h5A;
        check("R6 ptr held", preset_o[23:0], exp_pre[0]);

        // R11/R4 latch capture then byte-serial read with wrap
        for (int a = 0; a < 2; a++) begin
            cval = 24'hA1B2C3 ^ (24'h131313 * (a + 1));
            core_count_i[a*24 +: 24] = cval;
            for (int i = 0; i < 12; i++) snap[i] = stb_cnt[i];
            bus_write(1'b0, 1'b1, a[0], 8'h11);          // ptr reset + latch
            core_count_i[a*24 +: 24] = ~cval;
            check("R11 latch strobe", stb_cnt[8 + a] - snap[8 + a], 1);
            bus_read(1'b1, 1'b0, a[0], rbyte, rdoe);      // R6 deselected read
            for (int k = 0; k < 4; k++) begin
                bus_read(1'b0, 1'b0, a[0], rbyte, rdoe);
                check("R4 latch byte", rbyte, cval[(k % 3)*8 +: 8]);
            end
        end

        // R5 flag reads
        core_flags_i = 16'h9C3E;
        bus_read(1'b0, 1'b1, 1'b0, rbyte, rdoe);
        check("R5 flags X", rbyte, 8'h3E);
        bus_read(1'b0, 1'b1, 1'b1, rbyte, rdoe);
        check("R5 flags Y", rbyte, 8'h9C);

        // R7 configuration targets per axis
        for (int t = 0; t < 3; t++) begin
            for (int a = 0; a < 2; a++) begin
                logic [4:0] v;
                v = 5'(7 * (t + 1) + 11 * a + 3);
                exp_cfg[t][a] = v;
                bus_write(1'b0, 1'b1, a[0], {1'b0, 2'(t + 1), v});
                for (int b = 0; b < 2; b++)
                    check("R7 cfg", cfg_of(t, b), exp_cfg[t][b]);
            end
        end

        // R8 broadcast
        for (int t = 0; t < 3; t++) begin
            logic [4:0] v;
            v = 5'(5'h15 ^ t);
            exp_cfg[t][0] = v; exp_cfg[t][1] = v;
            bus_write(1'b0, 1'b1, 1'b0, {1'b1, 2'(t + 1), v});
            check("R8 bcast X", cfg_of(t, 0), v);
            check("R8 bcast Y", cfg_of(t, 1), v);
        end
        for (int i = 0; i < 12; i++) snap[i] = stb_cnt[i];
        bus_write(1'b0, 1'b1, 1'b0, 8'h82);
        check("R8 bcast rst X", stb_cnt[0] - snap[0], 1);
        check("R8 bcast rst Y", stb_cnt[1] - snap[1], 1);

        // R10/R11 full sweep of the reset/load low field
        for (int c = 0; c < 32; c++) begin
            for (int a = 0; a < 2; a++) begin
                for (int i = 0; i < 12; i++) snap[i] = stb_cnt[i];
                bus_write(1'b0, 1'b1, a[0], {3'b000, 5'(c)});
                for (int k = 0; k < 6; k++)
                    for (int x = 0; x < 2; x++)
                        check(k < 3 ? "R10 strobe" : "R11 strobe",
                              stb_cnt[k*2 + x] - snap[k*2 + x],
                              (x == a && fires(k, 5'(c))) ? 1 : 0);
            end
        end

        // R9 pointer reset mid-sequence
        bus_write(1'b0, 1'b0, 1'b1, 8'h77);
        bus_write(1'b0, 1'b1, 1'b1, 8'h01);
        bus_write(1'b0, 1'b0, 1'b1, 8'h66);
        check("R9 ptr reset", preset_o[47:24] & 24'h0000FF, 24'h66);

        // R12 pulse width over the whole run
        check("R12 single cycle", long_pulses, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule